// File: doc/BRIEF.md
# Temperature Sensor Two-Wire Slave Interface

This block is the serial front end of a digital temperature sensor. It listens on a two-wire (I2C/SMBus-compatible) bus and acts only as a slave. It takes SCL and SDA as raw inputs and oversamples them with the system clock. It pulls SDA low through an open-drain enable. Its 7-bit bus address has a fixed upper part `10010`, and the two low bits come from a four-state board strap.

A write first loads an 8-bit register pointer. The two low bits of the pointer select one of four 16-bit registers. Any data bytes that follow update the selected register, most significant byte first. A read returns the pointed register, most significant byte first, and the pointer stays as it was between transactions.

The block also handles these bus events:
- It answers the general-call reset.
- While the host's alert line is active, it answers the SMBus alert-response query. While sending the reply it watches for bit-wise arbitration loss.
- It recognises the high-speed master code.
- It drops out of a transaction when SCL stays low for too long.

The three writable registers are presented as parallel outputs. The temperature word comes in as a parallel input from the converter.

Top module: `tsense_i2c_slave`

## Requirements
- R1: The block acknowledges a slave address byte only when its upper seven bits equal `1001 0` followed by `strap_i[1:0]` (strap codes 00, 01, 10 and 11). Any other address that is not covered by R7, R8 or R10 gets no acknowledge.
- R2: The pointer resets to 00. It keeps its last written value across transactions, so a read with no preceding pointer write returns the register that was last pointed to.
- R3: The byte after an acknowledged write address is taken as the pointer. Its bits [1:0] select the register: 00 = temperature, 01 = configuration, 10 = low limit, 11 = high limit. The next two bytes replace bits [15:8] and then bits [7:0] of that register. Reset values are 0x60A0, 0x4B00 and 0x5000.
- R4: A read sends bits [15:8] of the pointed register and then bits [7:0], MSB first. A master NACK after the first byte ends the read, and SDA is released.
- R5: A write that stops after one data byte changes only bits [15:8] of the selected register.
- R6: Writes with pointer 00 are acknowledged but change nothing. Reads with pointer 00 return `temp_i`.
- R7: The block acknowledges the general-call address byte 0x00 and the byte after it. If that second byte is 0x06, the three writable registers and the pointer return to their reset values. Any other command byte leaves them unchanged.
- R8: While `alert_act_i` is 1, the block acknowledges the address byte 0x19 (address 0001100 with R/W = 1). It then returns its own 7-bit address followed by `alert_stat_i`, and pulses `alert_clr_o` after the eighth bit. While `alert_act_i` is 0, the byte 0x19 is not acknowledged.
- R9: During the alert-response reply, if SDA reads 0 while the block is sending a 1, the block releases SDA for the rest of that transfer and does not pulse `alert_clr_o`.
- R10: A first byte of the form `00001xxx` is not acknowledged and sets `hs_mode_o`. `hs_mode_o` stays set until the next STOP.
- R11: If SCL stays low for `TIMEOUT_CYC` system clocks during a transaction, the block releases SDA and ignores the bus until the next START.
- R12: `sda_oe_o` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 2 | Decoded address strap, low two address bits |
| temp_i | input | 16 | Current temperature word from the converter |
| alert_act_i | input | 1 | Alert condition active |
| alert_stat_i | input | 1 | Status bit returned in the alert-response reply |
| alert_clr_o | output | 1 | One-cycle pulse when the alert reply wins arbitration |
| cfg_o | output | 16 | Configuration register |
| tlow_o | output | 16 | Low limit register |
| thigh_o | output | 16 | High limit register |
| hs_mode_o | output | 1 | High-speed master code seen since the last STOP |

## Verification
The assertions assume a legal bus:
- SDA changes only while SCL is low, except for START and STOP.
- The master never pulls SDA against an acknowledge that the block is driving.
- Every SCL phase lasts well over the synchronizer delay.

The bench master keeps each SCL half-period at twelve system clocks and moves SDA only in the middle of a low phase. It drives SDA against the block only in the alert-reply arbitration case, and there it overrides a bit that the block is releasing. The timeout test is the only place where SCL stays low past the limit.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] ADDR_FIXED = 5'b10010;
  localparam logic [6:0] ARA_ADDR   = 7'b0001100;
  localparam logic [7:0] GC_RESET   = 8'h06;
  localparam logic [4:0] HS_PREFIX  = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACKW, ST_ACK, ST_TX, ST_TX_ACKW, ST_MACK
  } tsi_state_e;

  typedef enum logic [2:0] {
    CX_ADDR, CX_PTR, CX_MS, CX_LS, CX_GC, CX_SINK
  } tsi_ctx_e;

  typedef enum logic [2:0] {
    AK_NONE, AK_SELF_W, AK_SELF_R, AK_GCALL, AK_ARA, AK_HS
  } tsi_addr_e;

  function automatic logic [6:0] own_addr(input logic [1:0] strap);
    return {ADDR_FIXED, strap};
  endfunction

  function automatic tsi_addr_e classify(input logic [7:0] b,
                                         input logic [6:0] own,
                                         input logic alert);
    if (b[7:1] == own)                          return b[0] ? AK_SELF_R : AK_SELF_W;
    else if (b == 8'h00)                        return AK_GCALL;
    else if (b[7:1] == ARA_ADDR && b[0] && alert) return AK_ARA;
    else if (b[7:3] == HS_PREFIX)               return AK_HS;
    else                                        return AK_NONE;
  endfunction
endpackage

// File: rtl/tsi_sync.sv
module tsi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/tsi_timeout.sv
module tsi_timeout #(
  parameter int TIMEOUT_CYC = 3_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic scl_low,
  output logic hit
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);
  logic [CW-1:0] cnt;

  assign hit = active && scl_low && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (!active || !scl_low || hit) cnt <= '0;
    else                                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tsi_regfile.sv
module tsi_regfile #(
  parameter int          BW         = 8,
  parameter int          W          = 2 * BW,
  parameter logic [W-1:0] CFG_INIT  = 16'h60A0,
  parameter logic [W-1:0] LOW_INIT  = 16'h4B00,
  parameter logic [W-1:0] HIGH_INIT = 16'h5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ms,
  input  logic          wr_ls,
  input  logic          gc_rst,
  input  logic [1:0]    sel,
  input  logic [BW-1:0] wdata,
  input  logic [W-1:0]  temp_i,
  output logic [W-1:0]  cfg_o,
  output logic [W-1:0]  tlow_o,
  output logic [W-1:0]  thigh_o,
  output logic [W-1:0]  rd_word
);
  localparam int NREG = 3;
  localparam logic [W-1:0] INIT [NREG] = '{CFG_INIT, LOW_INIT, HIGH_INIT};
  logic [W-1:0] held [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [1:0] IDX = 2'(g + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held[g] <= INIT[g];
      else if (gc_rst) held[g] <= INIT[g];
      else if (sel == IDX) begin
        if (wr_ms) held[g][W-1:BW] <= wdata;
        if (wr_ls) held[g][BW-1:0] <= wdata;
      end
    end
  end

  assign cfg_o   = held[0];
  assign tlow_o  = held[1];
  assign thigh_o = held[2];

  always_comb begin
    case (sel)
      2'd0:    rd_word = temp_i;
      2'd1:    rd_word = held[0];
      2'd2:    rd_word = held[1];
      default: rd_word = held[2];
    endcase
  end
endmodule

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int BW = 8,
  parameter int W  = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          to_hit,
  input  logic [1:0]    strap,
  input  logic          alert_act,
  input  logic          alert_stat,
  input  logic [W-1:0]  rd_word,
  output logic          busy,
  output logic          sda_oe,
  output logic          hs_mode,
  output logic [BW-1:0] ptr,
  output logic          ptr_load,
  output logic          wr_ms,
  output logic          wr_ls,
  output logic [BW-1:0] wdata,
  output logic          gc_rst,
  output logic          alert_clr,
  output logic          arb_lost
);
  localparam int BC_W = $clog2(BW);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BW - 1);

  tsi_state_e     st;
  tsi_ctx_e       cx;
  logic [BC_W-1:0] bitc;
  logic [BW-1:0]  sh, tx;
  logic           ack_q, rd_q, ara_q, lsb_q, cont_q;

  logic [BW-1:0] rx_byte;
  logic [6:0]    own;
  tsi_addr_e     kind;

  assign rx_byte = {sh[BW-2:0], sda_lvl};
  assign own     = own_addr(strap);
  assign kind    = classify(rx_byte, own, alert_act);
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cx <= CX_ADDR; bitc <= '0; sh <= '0; tx <= '1;
      ack_q <= 1'b0; rd_q <= 1'b0; ara_q <= 1'b0; lsb_q <= 1'b0; cont_q <= 1'b0;
      sda_oe <= 1'b0; hs_mode <= 1'b0; ptr <= '0; wdata <= '0;
      ptr_load <= 1'b0; wr_ms <= 1'b0; wr_ls <= 1'b0; gc_rst <= 1'b0;
      alert_clr <= 1'b0; arb_lost <= 1'b0;
    end else begin
      ptr_load <= 1'b0; wr_ms <= 1'b0; wr_ls <= 1'b0; gc_rst <= 1'b0;
      alert_clr <= 1'b0; arb_lost <= 1'b0;
      if (to_hit) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else if (ev_start) begin
        st <= ST_RX; cx <= CX_ADDR; bitc <= '0; sda_oe <= 1'b0; ara_q <= 1'b0;
      end else if (ev_stop) begin
        st <= ST_IDLE; sda_oe <= 1'b0; hs_mode <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_RX: if (scl_rise) begin
            sh <= rx_byte;
            if (bitc != LAST_BIT) bitc <= bitc + 1'b1;
            else begin
              bitc  <= '0;
              st    <= ST_RX_ACKW;
              wdata <= rx_byte;
              ack_q <= 1'b1;
              rd_q  <= 1'b0;
              unique case (cx)
                CX_ADDR: begin
                  unique case (kind)
                    AK_SELF_W: cx <= CX_PTR;
                    AK_SELF_R: begin
                      rd_q <= 1'b1; lsb_q <= 1'b0; tx <= rd_word[W-1:BW];
                    end
                    AK_GCALL: cx <= CX_GC;
                    AK_ARA: begin
                      rd_q <= 1'b1; ara_q <= 1'b1; tx <= {own, alert_stat};
                    end
                    AK_HS: begin
                      ack_q <= 1'b0; hs_mode <= 1'b1;
                    end
                    default: ack_q <= 1'b0;
                  endcase
                end
                CX_PTR: begin
                  ptr <= rx_byte; ptr_load <= 1'b1; cx <= CX_MS;
                end
                CX_MS: begin
                  wr_ms <= 1'b1; cx <= CX_LS;
                end
                CX_LS: begin
                  wr_ls <= 1'b1; cx <= CX_SINK;
                end
                CX_GC: begin
                  if (rx_byte == GC_RESET) begin
                    gc_rst <= 1'b1; ptr <= '0;
                  end
                  cx <= CX_SINK;
                end
                default: ;
              endcase
            end
          end
          ST_RX_ACKW: if (scl_fall) begin
            sda_oe <= ack_q; st <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            bitc <= '0;
            if (!ack_q) begin
              st <= ST_IDLE; sda_oe <= 1'b0;
            end else if (rd_q) begin
              st <= ST_TX; sda_oe <= ~tx[BW-1];
            end else begin
              st <= ST_RX; sda_oe <= 1'b0;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              if (ara_q && tx[BW-1] && !sda_lvl) begin
                arb_lost <= 1'b1; st <= ST_IDLE; sda_oe <= 1'b0;
              end else if (bitc == LAST_BIT) begin
                st <= ST_TX_ACKW;
                if (ara_q) alert_clr <= 1'b1;
              end else begin
                bitc <= bitc + 1'b1;
              end
            end else if (scl_fall) begin
              tx <= {tx[BW-2:0], 1'b1}; sda_oe <= ~tx[BW-2];
            end
          end
          ST_TX_ACKW: if (scl_fall) begin
            sda_oe <= 1'b0; st <= ST_MACK;
          end
          ST_MACK: begin
            if (scl_rise) cont_q <= !sda_lvl && !ara_q && !lsb_q;
            else if (scl_fall) begin
              if (cont_q) begin
                tx <= rd_word[BW-1:0]; lsb_q <= 1'b1; bitc <= '0;
                sda_oe <= ~rd_word[BW-1]; st <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsense_i2c_slave.sv
module tsense_i2c_slave #(
  parameter int           SYNC_STAGES = 2,
  parameter int           TIMEOUT_CYC = 3_000_000,
  parameter logic [15:0]  CFG_INIT    = 16'h60A0,
  parameter logic [15:0]  TLOW_INIT   = 16'h4B00,
  parameter logic [15:0]  THIGH_INIT  = 16'h5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [1:0]  strap_i,
  input  logic [15:0] temp_i,
  input  logic        alert_act_i,
  input  logic        alert_stat_i,
  output logic        alert_clr_o,
  output logic [15:0] cfg_o,
  output logic [15:0] tlow_o,
  output logic [15:0] thigh_o,
  output logic        hs_mode_o
);
  localparam int BW = tsi_pkg::BYTE_W;
  localparam int W  = 2 * BW;
  localparam int NL = 2;

  logic [NL-1:0] raw, lvl, rise, fall;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NL; g++) begin : g_sync
    tsi_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[g]),
      .lvl(lvl[g]), .rise(rise[g]), .fall(fall[g])
    );
  end

  logic scl_lvl, scl_rise, scl_fall, sda_lvl;
  logic ev_start, ev_stop, to_hit, busy;
  logic ptr_load, wr_ms, wr_ls, gc_rst, arb_lost;
  logic [BW-1:0] ptr, wdata;
  logic [W-1:0]  rd_word;

  assign scl_lvl  = lvl[1];
  assign scl_rise = rise[1];
  assign scl_fall = fall[1];
  assign sda_lvl  = lvl[0];
  assign ev_start = scl_lvl && !scl_rise && fall[0];
  assign ev_stop  = scl_lvl && !scl_rise && rise[0];

  tsi_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_to (
    .clk(clk), .rst_n(rst_n), .active(busy), .scl_low(!scl_lvl), .hit(to_hit)
  );

  tsi_ctrl #(.BW(BW), .W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .ev_start(ev_start), .ev_stop(ev_stop), .to_hit(to_hit),
    .strap(strap_i), .alert_act(alert_act_i), .alert_stat(alert_stat_i),
    .rd_word(rd_word), .busy(busy), .sda_oe(sda_oe_o), .hs_mode(hs_mode_o),
    .ptr(ptr), .ptr_load(ptr_load), .wr_ms(wr_ms), .wr_ls(wr_ls),
    .wdata(wdata), .gc_rst(gc_rst), .alert_clr(alert_clr_o), .arb_lost(arb_lost)
  );

  tsi_regfile #(.BW(BW), .W(W), .CFG_INIT(CFG_INIT), .LOW_INIT(TLOW_INIT),
                .HIGH_INIT(THIGH_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ms(wr_ms), .wr_ls(wr_ls), .gc_rst(gc_rst),
    .sel(ptr[1:0]), .wdata(wdata), .temp_i(temp_i), .cfg_o(cfg_o),
    .tlow_o(tlow_o), .thigh_o(thigh_o), .rd_word(rd_word)
  );
endmodule

// File: rtl/tsense_i2c_slave_chk.sv
module tsense_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_oe_o,
  input logic       hs_mode_o,
  input logic       ev_stop,
  input logic       to_hit,
  input logic       wr_ms,
  input logic       wr_ls,
  input logic       gc_rst,
  input logic       ptr_load,
  input logic [7:0] ptr,
  input logic       arb_lost,
  input logic       alert_clr_o
);
  p_sda_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_lvl));

  p_stop_ends_hs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !hs_mode_o);

  p_timeout_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> !sda_oe_o);

  p_single_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ms, wr_ls, gc_rst}));

  p_lost_no_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> !alert_clr_o);

  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptr_load || gc_rst) |-> $stable(ptr));
endmodule

bind tsense_i2c_slave tsense_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe_o(sda_oe_o),
  .hs_mode_o(hs_mode_o), .ev_stop(ev_stop), .to_hit(to_hit), .wr_ms(wr_ms),
  .wr_ls(wr_ls), .gc_rst(gc_rst), .ptr_load(ptr_load), .ptr(ptr),
  .arb_lost(arb_lost), .alert_clr_o(alert_clr_o)
);

// File: tb/tsense_i2c_slave_tb.sv
module tsense_i2c_slave_tb;
  localparam int HP = 12;
  localparam int TO = 400;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic [1:0] strap = 2'b00;
  logic [15:0] temp = 16'h1900;
  logic act = 0, stat = 0;
  logic sda_oe, clr, hs;
  logic [15:0] cfg, tlow, thigh;
  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  tsense_i2c_slave #(.TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(strap), .temp_i(temp), .alert_act_i(act), .alert_stat_i(stat),
    .alert_clr_o(clr), .cfg_o(cfg), .tlow_o(tlow), .thigh_o(thigh), .hs_mode_o(hs)
  );

  int tests = 0, fails = 0, clr_cnt = 0, mcmp = 0, mbad = 0, r12_bad = 0;
  bit done = 0, cmp_en = 0;
  logic [15:0] m_regs [4];
  int m_ptr = 0;
  logic oe_prev = 0, scl_prev = 1;

  always @(negedge clk) begin
    if (clr) clr_cnt++;
    if (scl_m && scl_prev && sda_oe !== oe_prev) r12_bad++;
    oe_prev = sda_oe; scl_prev = scl_m;
    if (cmp_en) begin
      mcmp++;
      if (cfg !== m_regs[1] || tlow !== m_regs[2] || thigh !== m_regs[3]) mbad++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    tests++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask

  task automatic m_reset();
    m_regs[0] = 16'h0; m_regs[1] = 16'h60A0; m_regs[2] = 16'h4B00; m_regs[3] = 16'h5000;
    m_ptr = 0;
  endtask

  function automatic logic [15:0] m_read();
    return (m_ptr == 0) ? temp : m_regs[m_ptr];
  endfunction

  task automatic bstart();
    cmp_en = 0;
    sda_m = 1; hw(HP); scl_m = 1; hw(HP); sda_m = 0; hw(HP); scl_m = 0; hw(HP);
  endtask

  task automatic bstop();
    sda_m = 0; hw(HP); scl_m = 1; hw(HP); sda_m = 1; hw(HP);
    cmp_en = 1;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(HP); scl_m = 1; hw(HP); scl_m = 0;
    end
    sda_m = 1; hw(HP); scl_m = 1; hw(HP/2); ack = ~sda_line; hw(HP/2); scl_m = 0;
  endtask

  task automatic rd_byte(input logic mack, input logic [7:0] drv, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = drv[i]; hw(HP); scl_m = 1; hw(HP/2); b[i] = sda_line; hw(HP/2); scl_m = 0;
    end
    sda_m = ~mack; hw(HP); scl_m = 1; hw(HP); scl_m = 0; hw(2); sda_m = 1;
  endtask

  function automatic logic [7:0] addr(input logic rw);
    return {5'b10010, strap, rw};
  endfunction

  task automatic write_reg(input int p, input logic [15:0] v, input int nb);
    logic a;
    bstart(); wr_byte(addr(0), a); wr_byte(8'(p), a); m_ptr = p;
    wr_byte(v[15:8], a); if (p != 0) m_regs[p][15:8] = v[15:8];
    if (nb > 1) begin
      wr_byte(v[7:0], a); if (p != 0) m_regs[p][7:0] = v[7:0];
    end
    bstop();
  endtask

  task automatic read_word(output logic [15:0] w);
    logic a;
    bstart(); wr_byte(addr(1), a); rd_byte(1, 8'hFF, w[15:8]); rd_byte(0, 8'hFF, w[7:0]);
    bstop();
  endtask

  task automatic set_ptr(input int p);
    logic a;
    bstart(); wr_byte(addr(0), a); wr_byte(8'(p), a); m_ptr = p; bstop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [15:0] w;
    logic [7:0] b;
    int c0;
    m_reset();
    hw(5); rst_n = 1; hw(5); cmp_en = 1;

    chk("R3 reset cfg", cfg, 16'h60A0);
    chk("R3 reset limits", {tlow, thigh}, {16'h4B00, 16'h5000});
    chk("R11 reset oe/hs", {sda_oe, hs}, 2'b00);
    read_word(w); chk("R2 pointer 00 after reset", w, temp);

    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      bstart(); wr_byte(addr(0), a); bstop(); chk("R1 own address ack", a, 1);
      bstart(); wr_byte({5'b10010, 2'(s) ^ 2'b01, 1'b0}, a); bstop();
      chk("R1 foreign address nack", a, 0);
    end
    strap = 2'b00;

    write_reg(1, 16'h1234, 2); chk("R3 cfg word", cfg, 16'h1234);
    read_word(w); chk("R4 read MS then LS", w, 16'h1234);
    read_word(w); chk("R2 repeat read keeps pointer", w, m_read());
    write_reg(2, 16'hABCD, 2); chk("R3 low limit word", tlow, 16'hABCD);
    write_reg(3, 16'h7777, 1); chk("R5 MS byte only", thigh, 16'h7700);

    bstart(); wr_byte(addr(0), a); wr_byte(8'h00, a); m_ptr = 0;
    wr_byte(8'hDE, a); chk("R6 temp write acked", a, 1); wr_byte(8'hAD, a); bstop();
    chk("R6 other regs unchanged", {cfg, tlow, thigh}, {16'h1234, 16'hABCD, 16'h7700});
    read_word(w); chk("R6 temp read is input", w, temp);

    set_ptr(2);
    bstart(); wr_byte(addr(1), a); rd_byte(0, 8'hFF, b); bstop();
    chk("R4 early NACK MS byte", b, 8'hAB);
    chk("R4 SDA released after NACK", sda_oe, 0);

    bstart(); wr_byte(8'h00, a); chk("R7 general call ack", a, 1); wr_byte(8'h05, a); bstop();
    chk("R7 other command keeps regs", cfg, 16'h1234);
    bstart(); wr_byte(8'h00, a); wr_byte(8'h06, a); m_reset(); bstop();
    chk("R7 reset command", {cfg, tlow, thigh}, {16'h60A0, 16'h4B00, 16'h5000});
    read_word(w); chk("R7 pointer back to 00", w, temp);

    act = 0;
    bstart(); wr_byte(8'h19, a); bstop(); chk("R8 inactive alert query nack", a, 0);
    strap = 2'b01; act = 1; stat = 1; c0 = clr_cnt;
    bstart(); wr_byte(8'h19, a); chk("R8 alert query ack", a, 1);
    rd_byte(0, 8'hFF, b); bstop();
    chk("R8 reply address+status", b, 8'h93);
    chk("R8 clear pulse", clr_cnt - c0, 1);

    strap = 2'b00; stat = 0; c0 = clr_cnt;
    bstart(); wr_byte(8'h19, a); rd_byte(0, 8'h00, b); bstop();
    chk("R9 lost arbitration no clear", clr_cnt - c0, 0);
    chk("R9 SDA released", sda_oe, 0);
    act = 0;

    bstart(); wr_byte(8'h09, a); chk("R10 hs code nack", a, 0);
    chk("R10 hs flag set", hs, 1); bstop(); hw(4);
    chk("R10 hs flag cleared by STOP", hs, 0);

    temp = 16'h1900;
    set_ptr(0);
    bstart(); wr_byte(addr(1), a); hw(6);
    chk("R11 driving before timeout", sda_oe, 1);
    hw(TO + 20);
    chk("R11 released after timeout", sda_oe, 0);
    scl_m = 1; hw(HP); bstop();
    read_word(w); chk("R11 bus usable after timeout", w, temp);

    hw(10);
    chk("R3 R5 R7 model tracking mismatches", mbad, 0);
    chk("R12 SDA moved while SCL high", r12_bad, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule